// File: doc/BRIEF.md
# I2C Target Register Memory

This block is an I2C target that exposes a 128-byte register array to a bus controller. A single 8-bit register pointer selects the location for each access and advances on its own after every byte. The pointer keeps its value across STOP and START conditions. A controller sets it by writing one byte after a write-addressed START. It can then keep writing data bytes, or it can open a new transaction with the read address and stream bytes back.

The bus lines come in as raw samples of SCL and SDA. The lines are driven through open-drain enables: a high enable pulls the line low. Both inputs pass through synchronisers, and the block finds START, STOP and clock edges from the synchronised values.

In a read, the target holds SCL low after it acknowledges the read address, and again after each controller ACK. It releases SCL once the next byte has been fetched from the array. When the pointer has run past the top of the array, writes are dropped and reads return all ones.

The array is plain synchronous memory with a registered read port, so it maps to block RAM. It is not cleared by reset.

Top module: `i2c_regmem_target`

## Requirements
- R1: After reset both open-drain enables are low, and the register pointer is zero, so the first read after reset returns array location 0. The array contents survive reset.
- R2: The target ACKs an address byte (SDA pulled low in the ninth clock) only when bits 7..1 of the byte equal `dev_addr`; bit 0 is the R/W flag, 0 for write and 1 for read. On a mismatch it gives no ACK and ignores all bytes until the next START or STOP.
- R3: In a write transaction, the first byte after the address is loaded into the pointer and is not stored in the array.
- R4: Each later byte of a write is stored at the pointer, the pointer then increments by one, and the target ACKs the byte.
- R5: A write byte that arrives while the pointer is 128 or higher is still ACKed, but it is discarded and the pointer does not change. The pointer does not wrap around.
- R6: A read transaction returns bytes MSB first, starting at the pointer. The pointer increments after each byte is fetched.
- R7: A byte read while the pointer is 128 or higher is 0xFF, and the pointer does not change.
- R8: The pointer keeps its value across STOP, START and repeated START. A pointer-only write followed by a read, with or without a STOP between them, reads from the new pointer.
- R9: A controller NACK after a read byte ends the read. No further byte is driven and SDA stays released until the next START or STOP. A STOP releases both lines.
- R10: After acknowledging a read address or a controller ACK, the target pulls SCL low once per byte to be sent. It releases SCL when the byte is loaded, and it never starts pulling SCL while SCL is high.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| dev_addr | input | 7 | Static target address |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
The hardest case to reach is a write that crosses the top of the array part-way through a transaction. The bytes just below the top must land and the rest must be acknowledged and lost. The stimulus sets the pointer to 126 and sends four data bytes. It then shows that the pointer stuck at 128 by reading 0xFF twice. Reads from 126 and from 0 afterwards show that nothing wrapped around.

A mismatched address followed directly by a repeated START is used to show that the ignored bytes left the pointer alone. The clock stretch is shorter than the controller's own low time, so it cannot be seen in the bus timing. It is checked instead by counting stretch pulses against the number of bytes loaded.

// File: rtl/i2c_regmem_pkg.sv
package i2c_regmem_pkg;
  localparam int BYTE_W  = 8;
  localparam int TADDR_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_ACK,
    ST_WR,
    ST_WR_END,
    ST_RD_FETCH,
    ST_RD_LOAD,
    ST_RD_SHIFT,
    ST_RD_ACK,
    ST_RD_NEXT,
    ST_IGNORE
  } tgt_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_reg_ram.sv
module i2c_reg_ram #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_regmem_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int PTR_W = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [TADDR_W-1:0] dev_addr,
  input  logic [BYTE_W-1:0]  rd_data,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [BYTE_W-1:0]  mem_wdata,
  output logic               scl_oe,
  output logic               sda_oe
);
  tgt_state_t        state;
  logic [PTR_W-1:0]  ptr;
  logic [2:0]        cnt;
  logic [BYTE_W-1:0] rx;
  logic [BYTE_W-1:0] tx;
  logic              rw;
  logic              first;
  logic              in_range;
  logic              ptr_load;
  logic [BYTE_W-1:0] load_byte;

  assign in_range  = ({1'b0, ptr} < (PTR_W+1)'(DEPTH));
  assign ptr_load  = (state == ST_WR_END) && scl_fall && first;
  assign mem_we    = (state == ST_WR_END) && scl_fall && !first && in_range;
  assign mem_addr  = ptr[AW-1:0];
  assign mem_wdata = rx;
  assign load_byte = in_range ? rd_data : {BYTE_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      ptr    <= '0;
      cnt    <= '0;
      rx     <= '0;
      tx     <= '0;
      rw     <= 1'b0;
      first  <= 1'b0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            rx  <= {rx[BYTE_W-2:0], sda_s};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) state <= (state == ST_ADDR) ? ST_ADDR_END : ST_WR_END;
          end
        end
        ST_ADDR_END: begin
          if (scl_fall) begin
            if (rx[BYTE_W-1:1] == dev_addr) begin
              sda_oe <= 1'b1;
              rw     <= rx[0];
              first  <= ~rx[0];
              state  <= ST_ACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            if (rw) begin
              scl_oe <= 1'b1;
              state  <= ST_RD_FETCH;
            end else begin
              state <= ST_WR;
            end
          end
        end
        ST_WR_END: begin
          if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK;
            if (first) begin
              ptr   <= rx;
              first <= 1'b0;
            end else if (in_range) begin
              ptr <= ptr + 1'b1;
            end
          end
        end
        ST_RD_FETCH: state <= ST_RD_LOAD;
        ST_RD_LOAD: begin
          sda_oe <= ~load_byte[BYTE_W-1];
          tx     <= {load_byte[BYTE_W-2:0], 1'b1};
          if (in_range) ptr <= ptr + 1'b1;
          scl_oe <= 1'b0;
          cnt    <= '0;
          state  <= ST_RD_SHIFT;
        end
        ST_RD_SHIFT: begin
          if (scl_fall) begin
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_RD_ACK;
            end else begin
              sda_oe <= ~tx[BYTE_W-1];
              tx     <= {tx[BYTE_W-2:0], 1'b1};
              cnt    <= cnt + 3'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) state <= sda_s ? ST_IGNORE : ST_RD_NEXT;
        end
        ST_RD_NEXT: begin
          if (scl_fall) begin
            scl_oe <= 1'b1;
            state  <= ST_RD_FETCH;
          end
        end
        default: ;
      endcase
    end
  end

  // R10: the stretch only begins while SCL is already low
  assert_stretch_on_low_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> !scl_s) else $error("stretch started with SCL high");

  // R10: the stretch is released within two cycles
  assert_stretch_short_R10: assert property (@(posedge clk) disable iff (rst)
    $past(scl_oe) && $past(scl_oe, 2) |-> !scl_oe) else $error("stretch too long");

  // R11: SDA drive moves only while SCL is low
  assert_sda_on_low_R11: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det) |-> !$past(scl_s))
    else $error("SDA drive changed with SCL high");

  // R4: outside a pointer load the pointer only steps by one
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(ptr_load) && (ptr != $past(ptr)) |-> ptr == PTR_W'($past(ptr) + 1'b1))
    else $error("pointer jumped");

  // R5: the pointer sticks once past the array top
  assert_ptr_stuck_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(ptr_load) && ({1'b0, $past(ptr)} >= (PTR_W+1)'(DEPTH)) |-> ptr == $past(ptr))
    else $error("pointer moved beyond the top");

  // R9: STOP releases both lines; an ignoring target drives nothing
  assert_stop_release_R9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe && !scl_oe) else $error("lines held after STOP");
  assert_ignore_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_oe && !scl_oe) else $error("drive while ignoring");
endmodule

// File: rtl/i2c_regmem_target.sv
module i2c_regmem_target
  import i2c_regmem_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int PTR_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [TADDR_W-1:0] dev_addr,
  output logic               scl_oe,
  output logic               sda_oe
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              mem_we;
  logic [AW-1:0]     mem_addr;
  logic [BYTE_W-1:0] mem_wdata;
  logic [BYTE_W-1:0] mem_rdata;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .dev_addr(dev_addr),
    .rd_data(mem_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  i2c_reg_ram #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) u_ram (
    .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
  );
endmodule

// File: tb/test_i2c_regmem_target.sv
`timescale 1ns/1ps
module test_i2c_regmem_target;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h36;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl_low = 1'b0;
  logic m_sda_low = 1'b0;
  logic scl_oe, sda_oe;
  logic scl_line, sda_line;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  always #2.5 clk = ~clk;

  i2c_regmem_target i_i2c_regmem_target (
    .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
    .dev_addr(DEV), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int nchecks = 0;
  int nerr = 0;
  logic [7:0] model [128];
  int mptr = 0;
  int loads = 0;
  int rises = 0;
  int sda_bad = 0;
  logic prev_scl_oe = 1'b0;
  logic prev_sda_oe = 1'b0;
  logic prev_scl = 1'b1;

  int    exp_q [$];
  int    act_q [$];
  string tag_q [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // line monitor: stretch pulses and SDA changes under SCL high
  always @(negedge clk) begin
    if (!rst) begin
      if (scl_oe && !prev_scl_oe) rises++;
      if ((sda_oe != prev_sda_oe) && scl_line && prev_scl) sda_bad++;
    end
    prev_scl_oe <= scl_oe;
    prev_sda_oe <= sda_oe;
    prev_scl    <= scl_line;
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        int a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(a == e, t, a, e);
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; wq(Q);
    scl_up(); wq(Q);
    m_sda_low = 1'b1; wq(Q);
    m_scl_low = 1'b1; wq(2);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; wq(Q);
    scl_up(); wq(Q);
    m_sda_low = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = !b[i]; wq(Q);
      scl_up(); wq(Q);
      m_scl_low = 1'b1; wq(2);
    end
    m_sda_low = 1'b0; wq(Q);
    scl_up(); wq(Q);
    ack = sda_line;
    m_scl_low = 1'b1; wq(2);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_up(); wq(Q);
      b[i] = sda_line;
      m_scl_low = 1'b1; wq(2);
    end
    m_sda_low = !nack; wq(Q);
    scl_up(); wq(Q);
    m_scl_low = 1'b1; wq(2);
    m_sda_low = 1'b0;
  endtask

  task automatic write_txn(input logic [6:0] a, input int n,
                           input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3,
                           input logic [7:0] b4, input bit do_stop);
    logic [7:0] d [5];
    logic ack;
    bit matched;
    d[0] = b0; d[1] = b1; d[2] = b2; d[3] = b3; d[4] = b4;
    matched = (a == DEV);
    bus_start();
    send_byte({a, 1'b0}, ack);
    check(ack == !matched, "R2 address ack on write", ack, !matched);
    for (int k = 0; k < n; k++) begin
      string t;
      send_byte(d[k], ack);
      if (!matched) t = "R2 ignored byte ack";
      else if (k == 0) t = "R3 pointer byte ack";
      else if (mptr >= 128) t = "R5 dropped byte ack";
      else t = "R4 data byte ack";
      check(ack == !matched, t, ack, !matched);
      if (matched) begin
        if (k == 0) mptr = d[k];
        else if (mptr < 128) begin
          model[mptr] = d[k];
          mptr++;
        end
      end
    end
    if (do_stop) bus_stop();
  endtask

  task automatic read_txn(input int n, input string tag);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    check(ack == 1'b0, "R2 address ack on read", ack, 0);
    for (int k = 0; k < n; k++) begin
      int e;
      recv_byte(k == n - 1, b);
      loads++;
      e = (mptr < 128) ? int'(model[mptr]) : 32'hFF;
      if (mptr < 128) mptr++;
      exp_q.push_back(e);
      act_q.push_back(int'(b));
      tag_q.push_back(tag);
    end
  endtask

  // after a NACK the target must leave SDA alone
  task automatic idle_clocks();
    logic [8:0] seen;
    m_sda_low = 1'b0;
    for (int i = 0; i < 9; i++) begin
      wq(Q);
      scl_up(); wq(Q);
      seen[i] = sda_line;
      m_scl_low = 1'b1; wq(2);
    end
    check(seen == 9'h1FF, "R9 SDA released after NACK", seen, 9'h1FF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchecks++;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end

  initial begin
    wq(5);
    check(scl_oe == 1'b0, "R1 SCL released in reset", scl_oe, 0);
    check(sda_oe == 1'b0, "R1 SDA released in reset", sda_oe, 0);
    rst = 1'b0;
    wq(5);

    write_txn(DEV, 5, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 1'b1);
    write_txn(DEV, 2, 8'h05, 8'h5A, 8'h00, 8'h00, 8'h00, 1'b1);

    rst = 1'b1; wq(4);
    check(scl_oe == 1'b0, "R1 SCL released after reset", scl_oe, 0);
    check(sda_oe == 1'b0, "R1 SDA released after reset", sda_oe, 0);
    rst = 1'b0; mptr = 0; wq(5);

    read_txn(1, "R1 pointer zero after reset");
    idle_clocks();
    bus_stop();
    read_txn(3, "R8 pointer kept across STOP");
    bus_stop();

    write_txn(DEV, 1, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    read_txn(2, "R3 pointer-only write then repeated START read");
    bus_stop();

    write_txn(DEV, 1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1);
    write_txn(DEV ^ 7'h01, 2, 8'h03, 8'h77, 8'h00, 8'h00, 8'h00, 1'b0);
    read_txn(2, "R2 mismatched bytes left pointer and data");
    bus_stop();

    write_txn(DEV, 5, 8'h7E, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 1'b1);
    read_txn(2, "R7 read past top gives FF");
    bus_stop();
    write_txn(DEV, 1, 8'h7E, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    read_txn(3, "R5 bytes past top dropped");
    bus_stop();
    write_txn(DEV, 1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
    read_txn(4, "R6 sequential read from zero");
    bus_stop();
    write_txn(DEV, 1, 8'hC8, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1);
    read_txn(1, "R7 high pointer read gives FF");
    bus_stop();

    wq(10);
    check(rises == loads, "R10 one SCL stretch per loaded byte", rises, loads);
    check(sda_bad == 0, "R11 SDA changes only with SCL low", sda_bad, 0);
    check(exp_q.size() == 0, "R6 all read bytes compared", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule